// File: doc/BRIEF.md
# SPI Chip-Select Setup/Hold Sequencer

This block owns the active-low chip-select line of an SPI master for the length of one transfer. When a start request is accepted it pulls chip select low. It can then wait a programmable number of SPI clock periods before it allows the data shifter to begin. After the shifter reports that the data phase is done, it can keep chip select low for a second programmable number of SPI clock periods before it releases the line.

The SPI clock period reaches the block as a one-cycle tick enable. Both phase counters advance only on that tick. The prepare length is programmed as its length minus one. The hold length is programmed directly. Each of the two phases has its own enable bit and is skipped completely when that bit is clear. The timing fields and the enable bits are captured when a start is accepted, so they may be rewritten while a transfer is in progress.

Top module: `cs_seq_ctrl`

## Requirements
- R1: After reset, `cs_n_o` is 1, and `busy_o` and `data_go_o` are 0.
- R2: A `start_i` sampled while idle makes `cs_n_o` 0 and `busy_o` 1 from the next cycle.
- R3: With `setup_en_i` set, exactly `setup_len_i + 1` ticks are sampled while chip select is low before `data_go_o` pulses.
- R4: With `setup_en_i` clear, `data_go_o` pulses in the first cycle in which `cs_n_o` is 0.
- R5: `data_go_o` is a pulse one cycle long that occurs exactly once per transfer, and only while `cs_n_o` is 0.
- R6: During the data phase, ticks have no effect and chip select stays low until `data_done_i` is sampled. A `data_done_i` sampled while idle has no effect.
- R7: With `hold_en_i` set, chip select stays low after `data_done_i` for `hold_len_i` ticks, or for one tick when `hold_len_i` is 0.
- R8: With `hold_en_i` clear, `cs_n_o` returns to 1 in the cycle after `data_done_i` is sampled.
- R9: `busy_o` is always the inverse of `cs_n_o`.
- R10: A `start_i` that arrives while busy is ignored. It neither extends nor restarts the transfer and produces no extra `data_go_o`.
- R11: The lengths and the enable bits are captured at the accepted start. Changing them during the transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a transfer |
| tick_i | input | 1 | One-cycle enable marking each SPI clock period |
| data_done_i | input | 1 | Strobe from the shifter: the data phase has finished |
| setup_len_i | input | 4 | Prepare-phase length in ticks, minus one |
| hold_len_i | input | 4 | Hold-phase length in ticks |
| setup_en_i | input | 1 | Enables the prepare phase |
| hold_en_i | input | 1 | Enables the hold phase |
| cs_n_o | output | 1 | Chip select, active low |
| data_go_o | output | 1 | One-cycle pulse that starts the data phase |
| busy_o | output | 1 | A transfer is in progress |

## Verification
The hardest situation to reach from the ports is a late change of configuration. The lengths and enable bits must keep their captured values while the live inputs carry different values, and a start request must arrive in the middle of a phase. After every accepted start, the stimulus drives the bitwise complement of the timing fields and the enable bits. It also raises `start_i` during both the prepare phase and the data phase, and it spaces the ticks one, two or three cycles apart. Every combination of the two lengths and the two enable bits is run, so each measured tick count can only match the arithmetic expectation if the captured values were used.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_DATA  = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

endpackage

// File: rtl/cs_cfg_latch.sv
module cs_cfg_latch #(
    parameter int               LEN_W     = 4,
    parameter logic [LEN_W-1:0] SETUP_RST = 1,
    parameter logic [LEN_W-1:0] HOLD_RST  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] setup_len_i,
    input  logic [LEN_W-1:0] hold_len_i,
    input  logic             setup_en_i,
    input  logic             hold_en_i,
    output logic [LEN_W-1:0] setup_len_q,
    output logic [LEN_W-1:0] hold_len_q,
    output logic             setup_en_q,
    output logic             hold_en_q
);

    typedef struct packed {
        logic [LEN_W-1:0] setup_len;
        logic [LEN_W-1:0] hold_len;
        logic             setup_en;
        logic             hold_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d.setup_len = setup_len_i;
            cfg_d.hold_len  = hold_len_i;
            cfg_d.setup_en  = setup_en_i;
            cfg_d.hold_en   = hold_en_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{setup_len: SETUP_RST, hold_len: HOLD_RST,
                       setup_en: 1'b0, hold_en: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign setup_len_q = cfg_q.setup_len;
    assign hold_len_q  = cfg_q.hold_len;
    assign setup_en_q  = cfg_q.setup_en;
    assign hold_en_q   = cfg_q.hold_en;

endmodule

// File: rtl/cs_tick_cnt.sv
module cs_tick_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero,
    output logic             le_one
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign is_zero = (cnt_q == '0);
    assign le_one  = (cnt_q <= ONE);

endmodule

// File: rtl/cs_seq_ctrl.sv
module cs_seq_ctrl #(
    parameter int               LEN_W     = 4,
    parameter logic [LEN_W-1:0] SETUP_RST = 1,
    parameter logic [LEN_W-1:0] HOLD_RST  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tick_i,
    input  logic             data_done_i,
    input  logic [LEN_W-1:0] setup_len_i,
    input  logic [LEN_W-1:0] hold_len_i,
    input  logic             setup_en_i,
    input  logic             hold_en_i,
    output logic             cs_n_o,
    output logic             data_go_o,
    output logic             busy_o
);
    import cs_seq_pkg::*;

    typedef struct packed {
        phase_e ph;
        logic   go;
    } seq_t;

    seq_t seq_d, seq_q;
    phase_e state_q;

    logic             cfg_load;
    logic [LEN_W-1:0] setup_len_q, hold_len_q;
    logic             setup_en_q, hold_en_q;
    logic             cnt_load, cnt_dec, cnt_zero, cnt_le1;
    logic [LEN_W-1:0] cnt_val;

    cs_cfg_latch #(
        .LEN_W    (LEN_W),
        .SETUP_RST(SETUP_RST),
        .HOLD_RST (HOLD_RST)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cfg_load),
        .setup_len_i(setup_len_i),
        .hold_len_i (hold_len_i),
        .setup_en_i (setup_en_i),
        .hold_en_i  (hold_en_i),
        .setup_len_q(setup_len_q),
        .hold_len_q (hold_len_q),
        .setup_en_q (setup_en_q),
        .hold_en_q  (hold_en_q)
    );

    cs_tick_cnt #(
        .CNT_W(LEN_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .dec     (cnt_dec),
        .is_zero (cnt_zero),
        .le_one  (cnt_le1)
    );

    always_comb begin
        seq_d    = seq_q;
        seq_d.go = 1'b0;
        cfg_load = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = setup_len_i;
        cnt_dec  = 1'b0;
        case (seq_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    cfg_load = 1'b1;
                    if (setup_en_i) begin
                        seq_d.ph = PH_SETUP;
                        cnt_load = 1'b1;
                        cnt_val  = setup_len_i;
                    end else begin
                        seq_d.ph = PH_DATA;
                        seq_d.go = 1'b1;
                    end
                end
            end
            PH_SETUP: begin
                if (tick_i) begin
                    if (cnt_zero) begin
                        seq_d.ph = PH_DATA;
                        seq_d.go = 1'b1;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
            end
            PH_DATA: begin
                if (data_done_i) begin
                    if (hold_en_q) begin
                        seq_d.ph = PH_HOLD;
                        cnt_load = 1'b1;
                        cnt_val  = hold_len_q;
                    end else begin
                        seq_d.ph = PH_IDLE;
                    end
                end
            end
            PH_HOLD: begin
                if (tick_i) begin
                    if (cnt_le1) begin
                        seq_d.ph = PH_IDLE;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_IDLE, go: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_q   = seq_q.ph;
    assign cs_n_o    = (seq_q.ph == PH_IDLE);
    assign busy_o    = (seq_q.ph != PH_IDLE);
    assign data_go_o = seq_q.go;

endmodule

// File: rtl/cs_seq_chk.sv
module cs_seq_chk (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               tick_i,
    input logic               data_done_i,
    input logic               cs_n_o,
    input logic               data_go_o,
    input logic               busy_o,
    input cs_seq_pkg::phase_e state_q
);
    import cs_seq_pkg::*;

    // R5
    go_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_go_o |-> !cs_n_o);

    // R5
    go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_go_o |=> !data_go_o);

    // R9
    busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == !cs_n_o);

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && state_q != PH_HOLD && !data_done_i) |=> busy_o);

    // R2
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> !cs_n_o);

    // R6
    idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> cs_n_o);

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_DATA && !data_done_i) |=> (state_q == PH_DATA));

    // R3
    setup_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_SETUP && !tick_i) |=> (state_q == PH_SETUP));

    // R7
    hold_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_HOLD && !tick_i) |=> (state_q == PH_HOLD));
endmodule

bind cs_seq_ctrl cs_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .tick_i     (tick_i),
    .data_done_i(data_done_i),
    .cs_n_o     (cs_n_o),
    .data_go_o  (data_go_o),
    .busy_o     (busy_o),
    .state_q    (state_q)
);

// File: tb/sim_cs_seq_ctrl.sv
`timescale 1ns/1ps
module sim_cs_seq_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, tick_i = 1'b0, data_done_i = 1'b0;
    logic [3:0] setup_len_i = '0, hold_len_i = '0;
    logic setup_en_i = 1'b0, hold_en_i = 1'b0;
    logic cs_n_o, data_go_o, busy_o;
    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cs_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tick_i(tick_i),
        .data_done_i(data_done_i), .setup_len_i(setup_len_i),
        .hold_len_i(hold_len_i), .setup_en_i(setup_en_i),
        .hold_en_i(hold_en_i), .cs_n_o(cs_n_o), .data_go_o(data_go_o),
        .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int s, input int h, input bit se, input bit he, input int gap);
        int ticks;
        int exp_s;
        int exp_h;
        exp_s = se ? s + 1 : 0;
        exp_h = he ? ((h == 0) ? 1 : h) : 0;
        @(negedge clk);
        setup_len_i = 4'(s); hold_len_i = 4'(h);
        setup_en_i = se; hold_en_i = he; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!cs_n_o && busy_o, "R2", int'(cs_n_o), 0);
        // R11: live inputs change after capture
        setup_len_i = ~setup_len_i; hold_len_i = ~hold_len_i;
        setup_en_i = ~setup_en_i; hold_en_i = ~hold_en_i;
        ticks = 0;
        for (int k = 0; k < 200; k++) begin
            if (data_go_o) break;
            chk(busy_o == !cs_n_o, "R9", int'(busy_o), int'(!cs_n_o));
            tick_i = ((k % gap) == 0);
            start_i = (k == 1); // R10 during prepare phase
            if (tick_i) ticks++;
            @(negedge clk);
        end
        tick_i = 1'b0; start_i = 1'b0;
        chk(ticks == exp_s, se ? "R3/R11" : "R4/R11", ticks, exp_s);
        chk(!cs_n_o, "R5", int'(cs_n_o), 0);
        for (int k = 0; k < 5; k++) begin
            tick_i = 1'b1;
            start_i = (k == 2); // R10 during data phase
            @(negedge clk);
            chk(!cs_n_o && !data_go_o, "R6/R10/R5", int'(cs_n_o) + 2 * int'(data_go_o), 0);
        end
        tick_i = 1'b0; start_i = 1'b0;
        data_done_i = 1'b1;
        @(negedge clk);
        data_done_i = 1'b0;
        ticks = 0;
        for (int k = 0; k < 200; k++) begin
            if (cs_n_o) break;
            chk(busy_o && !data_go_o, "R9/R5", int'(busy_o), 1);
            tick_i = ((k % gap) == 0);
            if (tick_i) ticks++;
            @(negedge clk);
        end
        tick_i = 1'b0;
        chk(ticks == exp_h, he ? "R7/R11" : "R8/R11", ticks, exp_h);
        chk(!busy_o && !data_go_o, "R9", int'(busy_o), 0);
        data_done_i = 1'b1;
        @(negedge clk);
        data_done_i = 1'b0;
        @(negedge clk);
        chk(cs_n_o && !busy_o, "R6", int'(cs_n_o), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n_o && !busy_o && !data_go_o, "R1", int'(cs_n_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n_o && !busy_o && !data_go_o, "R1", int'(busy_o), 0);
        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 16; s++)
                for (int h = 0; h < 16; h++)
                    run(s, h, m[0], m[1], 1 + ((s + h + m) % 3));
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule